// File: doc/BRIEF.md
# Configuration Window Base Decoder

This block holds the programmable base register of a memory-mapped configuration window and answers, for any memory address presented to it, whether that address falls inside the window and at what offset. Software programs a 64-bit register through a byte-enabled write port. Bit 0 of that register switches the window on. Bits 2:1 select the window size. The upper bits give the base. The register can be read back at any time.

The register value and the decoded mapping are kept separate. The mapping is the enable, the aligned base and the size mask that the lookup side uses. A write that selects the reserved size code still lands in the register. The mapping that was in force stays in force, and a one-cycle guest-error pulse is raised. The lookup port is purely combinational against the registered mapping, so a decode answer costs no cycles.

Top module: `cwin_decoder`

## Requirements
- R1: After reset the read-back value equals the parameter RESET_VALUE (default 0xB000_0000, window disabled), no address hits, and guest_err is low.
- R2: A write with wr_en high updates only the bytes whose wr_be bit is set (bit b covers data bits 8b+7:8b). The new value is visible on rd_data from the clock edge that takes the write. A write with all byte enables low changes nothing.
- R3: An address can hit only while the active mapping has its enable bit set (register bit 0 = 1). With bit 0 clear, every address misses.
- R4: Size code 00 in register bits 2:1 selects a 256 MiB window. Only base bits 35:28 are significant, and register bits 27:0 do not move the window.
- R5: Size code 01 selects a 128 MiB window, and base bits 35:27 are significant.
- R6: Size code 10 selects a 64 MiB window, and base bits 35:26 are significant.
- R7: Size code 11 is reserved. A write that leaves it in the register updates rd_data but keeps the previous enable, base and size in force. guest_err is high for the cycle after that write edge.
- R8: While lk_hit is high, lk_off equals lk_addr minus the effective base. While lk_hit is low, lk_off is zero.
- R9: A new mapping takes effect at the clock edge that takes the write. A lookup made in the write cycle itself uses the old mapping.
- R10: A write touching any single byte recomputes the mapping from the merged register value. For example, writing only byte 0 can enable the window or change its size.
- R11: Register bits above bit 35 never affect the window. Any lookup address with a bit set above bit 35, or at or beyond base plus window size, misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 8 | Byte enables for the write |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Current register value |
| lk_addr | input | 64 | Address to decode |
| lk_hit | output | 1 | Address lies inside the active window |
| lk_off | output | 28 | Offset of the address inside the window |
| guest_err | output | 1 | One-cycle pulse after a write leaving the reserved size code |

## Verification
The checker watches several rules on every cycle. A hit never occurs without an enabled mapping. The offset is zero on a miss and fits inside the window mask on a hit. The register and the mapping stay stable across cycles with no write. A guest-error pulse follows only a write edge, and the mapping holds across that edge. The exact window bounds for each size code, the discarding of low and high base bits, the merge of partial writes and the old-mapping answer in the write cycle depend on chosen values, so only the directed scenarios of the bench can show them.

// File: rtl/cwin_pkg.sv
package cwin_pkg;

    localparam int CW_EN_BIT = 0;
    localparam int CW_SZ_LSB = 1;

    typedef enum logic [1:0] {
        SZ_256M = 2'b00,
        SZ_128M = 2'b01,
        SZ_64M  = 2'b10,
        SZ_RSVD = 2'b11
    } win_size_e;

    typedef struct packed {
        logic      en;
        win_size_e size;
    } win_ctl_t;

    function automatic logic size_reserved(win_size_e s);
        return s == SZ_RSVD;
    endfunction

    // lowest significant base bit: each size step halves the window
    function automatic int size_lsb(win_size_e s, int max_lsb);
        return max_lsb - int'(s);
    endfunction

endpackage

// File: rtl/cwin_regfile.sv
module cwin_regfile #(
    parameter int          DATA_W      = 64,
    parameter logic [63:0] RESET_VALUE = 64'h0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     q,
    output logic [DATA_W-1:0]     merged,
    output logic                  commit
);
    localparam int NBYTES = DATA_W / 8;

    assign commit = wr_en && (wr_be != '0);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : q[b*8 +: 8];

        always_ff @(posedge clk) begin
            if (rst) begin
                q[b*8 +: 8] <= RESET_VALUE[b*8 +: 8];
            end else if (wr_en && wr_be[b]) begin
                q[b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/cwin_mapper.sv
module cwin_mapper
    import cwin_pkg::*;
#(
    parameter int          ADDR_W      = 64,
    parameter int          MASK_HI     = 35,
    parameter int          MAX_LSB     = 28,
    parameter logic [63:0] RESET_VALUE = 64'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [ADDR_W-1:0] cand,
    output logic              map_en,
    output logic [ADDR_W-1:0] map_base,
    output logic [ADDR_W-1:0] map_lowmask,
    output logic              guest_err
);
    function automatic win_ctl_t ctl_of(logic [ADDR_W-1:0] v);
        win_ctl_t c;
        c.en   = v[CW_EN_BIT];
        c.size = win_size_e'(v[CW_SZ_LSB +: 2]);
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] keep_mask(int lsb);
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i <= MASK_HI) && (i >= lsb);
        end
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] low_mask(int lsb);
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i < lsb);
        end
        return m;
    endfunction

    localparam logic [ADDR_W-1:0] RST_V = RESET_VALUE[ADDR_W-1:0];

    win_ctl_t          cand_ctl;
    win_ctl_t          rst_ctl;
    logic [ADDR_W-1:0] cand_base, cand_low;
    logic [ADDR_W-1:0] rst_base, rst_low;

    always_comb begin
        cand_ctl  = ctl_of(cand);
        cand_base = cand & keep_mask(size_lsb(cand_ctl.size, MAX_LSB));
        cand_low  = low_mask(size_lsb(cand_ctl.size, MAX_LSB));
        rst_ctl   = ctl_of(RST_V);
        rst_base  = RST_V & keep_mask(size_lsb(rst_ctl.size, MAX_LSB));
        rst_low   = low_mask(size_lsb(rst_ctl.size, MAX_LSB));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_en      <= rst_ctl.en;
            map_base    <= rst_base;
            map_lowmask <= rst_low;
            guest_err   <= 1'b0;
        end else begin
            guest_err <= 1'b0;
            if (commit) begin
                if (size_reserved(cand_ctl.size)) begin
                    guest_err <= 1'b1;
                end else begin
                    map_en      <= cand_ctl.en;
                    map_base    <= cand_base;
                    map_lowmask <= cand_low;
                end
            end
        end
    end

endmodule

// File: rtl/cwin_lookup.sv
module cwin_lookup #(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 28
) (
    input  logic              map_en,
    input  logic [ADDR_W-1:0] map_base,
    input  logic [ADDR_W-1:0] map_lowmask,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [OFF_W-1:0]  off
);
    logic [OFF_W-1:0] diff;

    always_comb begin
        hit  = map_en && ((addr & ~map_lowmask) == map_base);
        diff = addr[OFF_W-1:0] - map_base[OFF_W-1:0];
        off  = hit ? diff : '0;
    end

endmodule

// File: rtl/cwin_decoder.sv
module cwin_decoder #(
    parameter int          ADDR_W      = 64,
    parameter int          MASK_HI     = 35,
    parameter int          MAX_LSB     = 28,
    parameter logic [63:0] RESET_VALUE = 64'h0000_0000_B000_0000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W/8-1:0]   wr_be,
    input  logic [ADDR_W-1:0]     wr_data,
    output logic [ADDR_W-1:0]     rd_data,
    input  logic [ADDR_W-1:0]     lk_addr,
    output logic                  lk_hit,
    output logic [MAX_LSB-1:0]    lk_off,
    output logic                  guest_err
);
    localparam int OFF_W = MAX_LSB;

    logic [ADDR_W-1:0] merged;
    logic              commit;
    logic              map_en;
    logic [ADDR_W-1:0] map_base;
    logic [ADDR_W-1:0] map_lowmask;

    cwin_regfile #(
        .DATA_W      (ADDR_W),
        .RESET_VALUE (RESET_VALUE)
    ) i_regfile (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .q       (rd_data),
        .merged  (merged),
        .commit  (commit)
    );

    cwin_mapper #(
        .ADDR_W      (ADDR_W),
        .MASK_HI     (MASK_HI),
        .MAX_LSB     (MAX_LSB),
        .RESET_VALUE (RESET_VALUE)
    ) i_mapper (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .cand        (merged),
        .map_en      (map_en),
        .map_base    (map_base),
        .map_lowmask (map_lowmask),
        .guest_err   (guest_err)
    );

    cwin_lookup #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) i_lookup (
        .map_en      (map_en),
        .map_base    (map_base),
        .map_lowmask (map_lowmask),
        .addr        (lk_addr),
        .hit         (lk_hit),
        .off         (lk_off)
    );

endmodule

// File: rtl/cwin_decoder_chk.sv
module cwin_decoder_chk #(
    parameter int ADDR_W  = 64,
    parameter int MAX_LSB = 28
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W/8-1:0] wr_be,
    input logic [ADDR_W-1:0]   rd_data,
    input logic                lk_hit,
    input logic [MAX_LSB-1:0]  lk_off,
    input logic                guest_err,
    input logic                map_en,
    input logic [ADDR_W-1:0]   map_base,
    input logic [ADDR_W-1:0]   map_lowmask
);
    logic wrote;
    assign wrote = wr_en && (wr_be != '0);

    p_hit_needs_enable_r3: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> map_en);

    p_offset_zero_on_miss_r8: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_off == '0));

    p_offset_in_window_r8: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ((ADDR_W'(lk_off) & ~map_lowmask) == '0));

    p_reserved_holds_map_r7: assert property (@(posedge clk) disable iff (rst)
        guest_err |-> ($stable(map_en) && $stable(map_base) && $stable(map_lowmask)));

    p_err_follows_write_r7: assert property (@(posedge clk) disable iff (rst)
        guest_err |-> $past(wrote));

    p_idle_keeps_register_r2: assert property (@(posedge clk) disable iff (rst)
        !wrote |=> $stable(rd_data));

    p_idle_keeps_map_r9: assert property (@(posedge clk) disable iff (rst)
        !wrote |=> ($stable(map_en) && $stable(map_base) && $stable(map_lowmask)));

endmodule

bind cwin_decoder cwin_decoder_chk #(
    .ADDR_W  (ADDR_W),
    .MAX_LSB (MAX_LSB)
) i_cwin_decoder_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_be       (wr_be),
    .rd_data     (rd_data),
    .lk_hit      (lk_hit),
    .lk_off      (lk_off),
    .guest_err   (guest_err),
    .map_en      (map_en),
    .map_base    (map_base),
    .map_lowmask (map_lowmask)
);

// File: tb/test_cwin_decoder.sv
module test_cwin_decoder;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_be = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic [63:0] lk_addr = '0;
    logic        lk_hit;
    logic [27:0] lk_off;
    logic        guest_err;

    int total = 0;
    int bad = 0;
    logic [63:0] exp_reg;

    always #(CLK_PERIOD/2) clk = ~clk;

    cwin_decoder i_cwin_decoder (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .lk_addr   (lk_addr),
        .lk_hit    (lk_hit),
        .lk_off    (lk_off),
        .guest_err (guest_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input string req, input logic [63:0] a,
                        input logic h, input logic [27:0] o);
        lk_addr = a;
        #1;
        chk({req, " hit"}, 64'(lk_hit), 64'(h));
        chk({req, " off"}, 64'(lk_off), 64'(o));
    endtask

    task automatic do_write(input logic [63:0] d, input logic [7:0] be);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_be = be;
        for (int b = 0; b < 8; b++) if (be[b]) exp_reg[b*8 +: 8] = d[b*8 +: 8];
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic t_reset;
        chk("R1 rdata", rd_data, 64'h0000_0000_B000_0000);
        chk("R1 err", 64'(guest_err), 64'd0);
        look("R1", 64'h0000_0000_B000_0000, 1'b0, 28'h0);
        look("R3 disabled", 64'h0000_0000_B000_0010, 1'b0, 28'h0);
    endtask

    task automatic t_enable_byte0;
        do_write(64'hFFFF_FFFF_FFFF_FF01, 8'h01);
        chk("R10 rdata", rd_data, 64'h0000_0000_B000_0001);
        chk("R10 err", 64'(guest_err), 64'd0);
        look("R10 base", 64'h0000_0000_B000_0000, 1'b1, 28'h0);
        look("R8 offset", 64'h0000_0000_B000_1234, 1'b1, 28'h000_1234);
        look("R4 last", 64'h0000_0000_BFFF_FFFF, 1'b1, 28'hFFF_FFFF);
        look("R11 end", 64'h0000_0000_C000_0000, 1'b0, 28'h0);
        look("R11 below", 64'h0000_0000_AFFF_FFFF, 1'b0, 28'h0);
        look("R11 high addr", 64'h0000_0001_B000_0000, 1'b0, 28'h0);
    endtask

    task automatic t_be_none;
        do_write(64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
        chk("R2 no bytes", rd_data, exp_reg);
        chk("R2 no err", 64'(guest_err), 64'd0);
        look("R2 map kept", 64'h0000_0000_B000_0040, 1'b1, 28'h40);
    endtask

    task automatic t_be_partial;
        do_write(64'hAAAA_AAAA_AAAA_AAAA, 8'h80);
        chk("R2 byte7", rd_data, exp_reg);
        chk("R2 byte7 val", rd_data, 64'hAA00_0000_B000_0001);
        look("R11 reg high bits", 64'h0000_0000_B000_0100, 1'b1, 28'h100);
    endtask

    task automatic t_256_low_ignored;
        do_write(64'h0000_0000_E123_4561, 8'hFF);
        chk("R4 rdata", rd_data, 64'h0000_0000_E123_4561);
        look("R4 base", 64'h0000_0000_E000_0000, 1'b1, 28'h0);
        look("R4 mid", 64'h0000_0000_E123_4560, 1'b1, 28'h123_4560);
        look("R4 above", 64'h0000_0000_F000_0000, 1'b0, 28'h0);
    endtask

    task automatic t_128;
        do_write(64'h0000_0000_C800_0003, 8'hFF);
        look("R5 base", 64'h0000_0000_C800_0000, 1'b1, 28'h0);
        look("R5 last", 64'h0000_0000_CFFF_FFFF, 1'b1, 28'h7FF_FFFF);
        look("R5 end", 64'h0000_0000_D000_0000, 1'b0, 28'h0);
        look("R5 below", 64'h0000_0000_C7FF_FFFF, 1'b0, 28'h0);
    endtask

    task automatic t_64;
        do_write(64'h0000_0000_A400_0105, 8'hFF);
        chk("R6 rdata", rd_data, 64'h0000_0000_A400_0105);
        look("R6 base", 64'h0000_0000_A400_0000, 1'b1, 28'h0);
        look("R6 last", 64'h0000_0000_A7FF_FFFF, 1'b1, 28'h3FF_FFFF);
        look("R6 end", 64'h0000_0000_A800_0000, 1'b0, 28'h0);
        look("R6 below", 64'h0000_0000_A3FF_FFFF, 1'b0, 28'h0);
    endtask

    task automatic t_reserved;
        do_write(64'h0000_0000_5000_0007, 8'hFF);
        chk("R7 rdata", rd_data, 64'h0000_0000_5000_0007);
        chk("R7 err pulse", 64'(guest_err), 64'd1);
        look("R7 old kept", 64'h0000_0000_A400_0010, 1'b1, 28'h10);
        look("R7 new not used", 64'h0000_0000_5000_0000, 1'b0, 28'h0);
        @(negedge clk);
        chk("R7 err drops", 64'(guest_err), 64'd0);
        do_write(64'h0000_0000_0000_0005, 8'h01);
        chk("R10 merged", rd_data, 64'h0000_0000_5000_0005);
        chk("R10 err", 64'(guest_err), 64'd0);
        look("R10 new base", 64'h0000_0000_5000_0000, 1'b1, 28'h0);
        look("R10 old gone", 64'h0000_0000_A400_0010, 1'b0, 28'h0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 64'h0000_0000_9000_0001; wr_be = 8'hFF;
        exp_reg = 64'h0000_0000_9000_0001;
        look("R9 old in write cycle", 64'h0000_0000_5000_0020, 1'b1, 28'h20);
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
        look("R9 old gone", 64'h0000_0000_5000_0020, 1'b0, 28'h0);
        look("R9 new active", 64'h0000_0000_9000_0020, 1'b1, 28'h20);
    endtask

    task automatic t_upper;
        do_write(64'hFF00_0000_9000_0001, 8'hFF);
        look("R11 reg upper ignored", 64'h0000_0000_9000_0000, 1'b1, 28'h0);
        look("R11 addr upper", 64'hFF00_0000_9000_0000, 1'b0, 28'h0);
        do_write(64'h0000_0008_0000_0001, 8'hFF);
        look("R11 bit35 base", 64'h0000_0008_0000_0100, 1'b1, 28'h100);
        look("R11 bit35 missing", 64'h0000_0000_0000_0100, 1'b0, 28'h0);
    endtask

    task automatic t_disable;
        do_write(64'h0000_0000_0000_0000, 8'h01);
        chk("R3 rdata", rd_data, 64'h0000_0008_0000_0000);
        look("R3 off", 64'h0000_0008_0000_0100, 1'b0, 28'h0);
    endtask

    logic done = 1'b0;

    initial begin
        exp_reg = 64'h0000_0000_B000_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_byte0();
        t_be_none();
        t_be_partial();
        t_256_low_ignored();
        t_128();
        t_64();
        t_reserved();
        t_timing();
        t_upper();
        t_disable();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule